// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block adds interrupt handling to a processor's fetch-execute loop. Up to three device request lines are checked for pending work, but only at an instruction boundary. The status register holds a kernel-mode bit and a two-bit interrupt level. A request line is taken only when its priority is strictly above the current level. For a taken request, the block pulses an acknowledge to the chosen device and latches the type code that device returns. It then runs a fixed entry sequence. Each step of that sequence takes one cycle: push the PC and status onto a small save stack, set kernel mode, raise the level, and finally read the handler address from a vector table in low memory.

A return-from-interrupt pops the save stack. It gives the datapath the saved PC in the same cycle and restores mode and level on the next edge. The cycle after a return is treated as an instruction boundary, so a request left pending is taken at once if it now outranks the restored level. Nested entry is bounded by the save stack depth. A request that would nest past a full stack is not acknowledged and sets a sticky fault flag.

The vector table read is the only data path that leaves the block, and it is a valid/ready request. `vec_valid` stays high and `vec_addr` stays stable until the table side raises `vec_ready`. The entry completes in the cycle of that handshake, when `vec_data` is passed to the PC. The table side may hold `vec_ready` low for any number of cycles, and the sequencer simply waits. All other pins are plain control levels or strobes.

Top module: `irq_seq`

## Requirements
- R1: After reset, `kmode` is 0, `level` is 0, `inta`, `busy`, `vec_valid`, `pc_load` and `fault` are all 0.
- R2: Request lines are sampled only at an edge where `insn_done` is high, or in the cycle that follows an accepted return. A request held without either of these produces no acknowledge and leaves `busy` low.
- R3: Line i has priority i+1. Among the raised lines, the one with the highest index is chosen. It is accepted only when its priority is strictly greater than `level`. A request that is not accepted stays pending.
- R4: `inta` is a one-hot pulse, lasting exactly one cycle, in the cycle after the accepting edge. Bit i of `inta` belongs to line i. `irq_type` is captured at the edge that ends that pulse.
- R5: Entry order is as follows: save PC and status (edge 2 after the pulse), set `kmode` (edge 3), set `level` to the accepted priority (edge 4), then assert `vec_valid` with `vec_addr` equal to type×4. While `vec_ready` is low, `vec_valid` and `vec_addr` hold.
- R6: In the cycle where `vec_valid` and `vec_ready` are both high, `pc_load` is 1 and `pc_new` equals `vec_data`. `busy` is high from the acknowledge cycle through that cycle and low after it.
- R7: When `rti` is high in an idle cycle and the stack is not empty, `pc_load` is 1 and `pc_new` equals the saved PC in that cycle. `kmode` and `level` take their saved values at the next edge.
- R8: When `rti` is high with an empty stack, it is ignored: `pc_load` stays 0, and `kmode` and `level` are unchanged.
- R9: A request whose priority exceeds the level of a running handler preempts it. On return, the handler's own PC, kernel mode and level come back.
- R10: In the cycle after an accepted return, a pending request that outranks the restored level is acknowledged without `insn_done`.
- R11: When the stack holds DEPTH entries, a request that would otherwise be accepted gets no acknowledge and sets `fault`. `fault` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary strobe |
| rti | input | 1 | Return-from-interrupt executed |
| pc_cur | input | AW | Current PC from datapath |
| intr | input | NLINE | Device request lines |
| inta | output | NLINE | One-hot acknowledge pulse |
| irq_type | input | TW | Type code driven by acknowledged device |
| vec_valid | output | 1 | Vector table read request |
| vec_ready | input | 1 | Vector table read accepted, data valid |
| vec_addr | output | AW | Vector entry address (type×4) |
| vec_data | input | AW | Handler address from vector table |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | AW | Handler address or restored PC |
| kmode | output | 1 | Kernel mode bit |
| level | output | 2 | Current interrupt level |
| busy | output | 1 | Entry sequence in progress (stall fetch) |
| fault | output | 1 | Sticky save-stack overflow flag |

## Verification
The bench builds the block with DEPTH=2, NLINE=3, AW=16 and TW=4. With a two-entry stack, the overflow refusal and the sticky fault can be reached with only two nested handlers. The default depth of four cannot overflow with three priority levels, because the level rises strictly on each entry. Three lines fill every priority above level 0. This lets the bench reach preemption, blocking by level, and the pending-then-accepted-after-return path. A four-bit type exercises the vector addresses from 0x00 up to 0x3C.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACK,
    S_SAVE,
    S_MODE,
    S_MASK,
    S_FETCH
  } seq_state_t;

  typedef struct packed {
    logic             kmode;
    logic [LVL_W-1:0] lvl;
  } psr_t;

  localparam int PSR_W = LVL_W + 1;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int NLINE = 3,
  localparam int IW = (NLINE > 1) ? $clog2(NLINE) : 1
) (
  input  logic [NLINE-1:0] req,
  output logic             any,
  output logic [IW-1:0]    idx,
  output logic [LVL_W-1:0] prio
);
  // highest index wins; line i carries priority i+1
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    prio = '0;
    for (int i = 0; i < NLINE; i++) begin
      if (req[i]) begin
        any  = 1'b1;
        idx  = IW'(i);
        prio = LVL_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/irq_stack.sv
module irq_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 19,
  localparam int PW  = $clog2(DEPTH + 1),
  localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp;

  assign full  = (sp == PW'(DEPTH));
  assign empty = (sp == '0);
  assign dout  = mem[IXW'(sp - 1'b1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (push) begin
      mem[IXW'(sp)] <= din;
      sp            <= sp + 1'b1;
    end else if (pop) begin
      sp <= sp - 1'b1;
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_push_pop_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int NLINE = 3,
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int TW    = 4,
  localparam int IW = (NLINE > 1) ? $clog2(NLINE) : 1,
  localparam int SW = AW + PSR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_done,
  input  logic             rti,
  input  logic [AW-1:0]    pc_cur,
  input  logic [NLINE-1:0] intr,
  output logic [NLINE-1:0] inta,
  input  logic [TW-1:0]    irq_type,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [AW-1:0]    vec_addr,
  input  logic [AW-1:0]    vec_data,
  output logic             pc_load,
  output logic [AW-1:0]    pc_new,
  output logic             kmode,
  output logic [1:0]       level,
  output logic             busy,
  output logic             fault
);
  seq_state_t       state;
  psr_t             psr;
  logic [IW-1:0]    line_q;
  logic [LVL_W-1:0] prio_q;
  logic [TW-1:0]    type_q;
  logic             ret_chk;

  logic             any;
  logic [IW-1:0]    idx;
  logic [LVL_W-1:0] prio;
  logic             stk_push, stk_pop, stk_full, stk_empty;
  logic [SW-1:0]    stk_dout;
  logic             rti_go, want, accept, blocked;

  irq_pick #(.NLINE(NLINE)) u_pick (
    .req (intr),
    .any (any),
    .idx (idx),
    .prio(prio)
  );

  irq_stack #(.DEPTH(DEPTH), .W(SW)) u_stack (
    .clk  (clk),
    .rst_n(rst_n),
    .push (stk_push),
    .pop  (stk_pop),
    .din  ({pc_cur, psr}),
    .dout (stk_dout),
    .full (stk_full),
    .empty(stk_empty)
  );

  // a return outranks a boundary check in the same cycle
  assign rti_go   = (state == S_IDLE) && rti && !stk_empty;
  assign want     = (state == S_IDLE) && (insn_done || ret_chk) && any
                    && (prio > psr.lvl) && !rti_go;
  assign accept   = want && !stk_full;
  assign blocked  = want && stk_full;
  assign stk_push = (state == S_SAVE);
  assign stk_pop  = rti_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      psr     <= '0;
      line_q  <= '0;
      prio_q  <= '0;
      type_q  <= '0;
      ret_chk <= 1'b0;
      fault   <= 1'b0;
    end else begin
      ret_chk <= rti_go;
      fault   <= fault | blocked;
      unique case (state)
        S_IDLE: begin
          if (rti_go) begin
            psr <= psr_t'(stk_dout[PSR_W-1:0]);
          end else if (accept) begin
            line_q <= idx;
            prio_q <= prio;
            state  <= S_ACK;
          end
        end
        S_ACK: begin
          type_q <= irq_type;
          state  <= S_SAVE;
        end
        S_SAVE:  state <= S_MODE;
        S_MODE: begin
          psr.kmode <= 1'b1;
          state     <= S_MASK;
        end
        S_MASK: begin
          psr.lvl <= prio_q;
          state   <= S_FETCH;
        end
        S_FETCH: if (vec_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NLINE; i++) begin : g_ack
    assign inta[i] = (state == S_ACK) && (line_q == IW'(i));
  end

  assign vec_valid = (state == S_FETCH);
  assign vec_addr  = {{(AW-TW-2){1'b0}}, type_q, 2'b00};
  assign pc_load   = (vec_valid && vec_ready) || rti_go;
  assign pc_new    = rti_go ? stk_dout[SW-1:PSR_W] : vec_data;
  assign kmode     = psr.kmode;
  assign level     = psr.lvl;
  assign busy      = (state != S_IDLE);

  assert_inta_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inta));
  assert_inta_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inta != '0) |=> (inta == '0));
  assert_accept_above_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inta != '0) |-> (prio_q > psr.lvl));
  assert_kernel_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MODE) |=> kmode);
  assert_vec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr)));
  assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
endmodule

// File: tb/sim_irq_seq.sv
module sim_irq_seq;
  localparam int NLINE = 3;
  localparam int AW = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_done = 1'b0, rti = 1'b0, vec_ready = 1'b0;
  logic [AW-1:0] pc_cur = '0, vec_data = '0;
  logic [NLINE-1:0] intr = '0;
  logic [TW-1:0] irq_type = '0;
  logic [NLINE-1:0] inta;
  logic vec_valid, pc_load, kmode, busy, fault;
  logic [AW-1:0] vec_addr, pc_new;
  logic [1:0] level;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  irq_seq #(.NLINE(NLINE), .DEPTH(2), .AW(AW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .rti(rti), .pc_cur(pc_cur),
    .intr(intr), .inta(inta), .irq_type(irq_type), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_addr(vec_addr), .vec_data(vec_data),
    .pc_load(pc_load), .pc_new(pc_new), .kmode(kmode), .level(level),
    .busy(busy), .fault(fault));

  // accept-table: request pattern, type, handler, expected ack, expected level
  localparam logic [2:0]  T_INTR [5] = '{3'b001, 3'b110, 3'b000, 3'b011, 3'b111};
  localparam logic [3:0]  T_TYPE [5] = '{4'd5, 4'd2, 4'd0, 4'd0, 4'd15};
  localparam logic [15:0] T_HND  [5] = '{16'h1234, 16'h4400, 16'h0000, 16'h0A0A, 16'hBEEF};
  localparam logic [2:0]  T_ACK  [5] = '{3'b001, 3'b100, 3'b000, 3'b010, 3'b100};
  localparam logic [1:0]  T_LVL  [5] = '{2'd1, 2'd3, 2'd0, 2'd2, 2'd3};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; insn_done = 0; rti = 0; intr = '0; vec_ready = 0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic boundary();
    insn_done = 1'b1;
    tick();
    insn_done = 1'b0;
  endtask

  // starts in the acknowledge cycle
  task automatic finish_entry(input logic [2:0] ack, input logic [3:0] typ,
                              input logic [15:0] hnd, input logic [1:0] lvl, input int stall);
    check("R4 inta pulse", 32'(inta), 32'(ack));
    intr = intr & ~ack;
    irq_type = typ;
    tick();
    check("R4 inta ends", 32'(inta), 0);
    check("R6 busy during entry", 32'(busy), 1);
    tick(); tick();
    check("R5 kernel mode set", 32'(kmode), 1);
    tick();
    check("R5 level raised", 32'(level), 32'(lvl));
    check("R5 vector request", 32'(vec_valid), 1);
    check("R5 vector address", 32'(vec_addr), 32'(typ) * 4);
    for (int s = 0; s < stall; s++) begin
      tick();
      check("R5 valid held", 32'(vec_valid), 1);
      check("R5 address held", 32'(vec_addr), 32'(typ) * 4);
      check("R6 no load while stalled", 32'(pc_load), 0);
    end
    vec_ready = 1'b1; vec_data = hnd;
    #1;
    check("R6 handler load", 32'(pc_load), 1);
    check("R6 handler pc", 32'(pc_new), 32'(hnd));
    tick();
    vec_ready = 1'b0;
    check("R6 busy drops", 32'(busy), 0);
  endtask

  task automatic do_rti(input logic [15:0] pc, input logic km, input logic [1:0] lvl);
    rti = 1'b1;
    #1;
    check("R7 return load", 32'(pc_load), 1);
    check("R7 return pc", 32'(pc_new), 32'(pc));
    tick();
    rti = 1'b0;
    pc_cur = pc;
    check("R7 mode restored", 32'(kmode), 32'(km));
    check("R7 level restored", 32'(level), 32'(lvl));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 kmode", 32'(kmode), 0);
    check("R1 level", 32'(level), 0);
    check("R1 inta", 32'(inta), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 fault", 32'(fault), 0);
    check("R1 vec_valid", 32'(vec_valid), 0);

    // R8 return with empty stack
    rti = 1'b1;
    #1;
    check("R8 no load on empty return", 32'(pc_load), 0);
    tick();
    rti = 1'b0;
    check("R8 mode unchanged", 32'(kmode), 0);
    check("R8 level unchanged", 32'(level), 0);

    // R2 request without boundary is not taken
    intr = 3'b001;
    tick(); tick(); tick();
    check("R2 no ack without boundary", 32'(inta), 0);
    check("R2 idle without boundary", 32'(busy), 0);
    intr = '0;

    // R3 R5 R6 R7 table walk
    for (int v = 0; v < 5; v++) begin
      intr = T_INTR[v];
      pc_cur = 16'h0100 + 16'(v);
      boundary();
      if (T_ACK[v] == 3'b000) begin
        check("R3 nothing raised", 32'(inta), 0);
        check("R3 stays idle", 32'(busy), 0);
      end else begin
        finish_entry(T_ACK[v], T_TYPE[v], T_HND[v], T_LVL[v], v == 1 ? 2 : 0);
        intr = '0;
        do_rti(16'h0100 + 16'(v), 1'b0, 2'd0);
      end
    end

    // R3 blocked by level, R10 taken right after return
    intr = 3'b100; pc_cur = 16'h0300;
    boundary();
    finish_entry(3'b100, 4'd7, 16'h7000, 2'd3, 0);
    intr = 3'b010; pc_cur = 16'h7004;
    boundary();
    check("R3 lower priority held off", 32'(inta), 0);
    check("R3 stays idle when masked", 32'(busy), 0);
    do_rti(16'h0300, 1'b0, 2'd0);
    tick();
    finish_entry(3'b010, 4'd3, 16'h3000, 2'd2, 0);
    do_rti(16'h0300, 1'b0, 2'd0);

    // R9 nesting and R11 overflow with a two-entry stack
    intr = 3'b001; pc_cur = 16'h0500;
    boundary();
    finish_entry(3'b001, 4'd1, 16'h1000, 2'd1, 0);
    intr = 3'b010; pc_cur = 16'h1008;
    boundary();
    check("R9 preempting ack", 32'(inta), 3'b010);
    finish_entry(3'b010, 4'd2, 16'h2000, 2'd2, 0);
    intr = 3'b100; pc_cur = 16'h2004;
    boundary();
    check("R11 no ack on full stack", 32'(inta), 0);
    check("R11 fault set", 32'(fault), 1);
    intr = '0;
    tick();
    check("R11 fault sticky", 32'(fault), 1);
    do_rti(16'h1008, 1'b1, 2'd1);
    check("R9 handler mode back", 32'(kmode), 1);
    do_rti(16'h0500, 1'b0, 2'd0);

    do_reset();
    check("R1 fault cleared by reset", 32'(fault), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule